// File: doc/BRIEF.md
# T1 System-Side Frame Timing Generator

This block derives the system-side framing strobes that a receive elastic store and its signalling logic need. It runs from the system bit clock. It takes its frame alignment from the rising edge of a system frame sync input. One rate input selects between two frame formats. The first is a 193-bit frame: one framing-bit slot followed by 24 eight-bit channels. The second is a 256-bit frame of 32 eight-bit channels with no framing slot.

From the current bit position the block generates four outputs. The channel clock marks each channel boundary. The bit-8 strobe marks the last (least significant) bit of every channel. The high-channel flag marks the unused channels 25 to 32 of the wide frame, so that the data path can force them to ones. The multiframe pulse runs for a fixed 65 clocks at the start of each multiframe. A multiframe is 12 frames in the short mode and 24 frames in the extended mode. Once aligned, the counters run freely, and any later sync edge realigns them. All outputs are plain strobes; the block has no streaming interface and no back-pressure.

Top module: `t1_sys_timing`

## Requirements
- R1: After reset and until the first rising edge of `fsync` is sampled, `chan_clk`, `bit8`, `chan_hi` and `mf_pulse` are all low.
- R2: A rising edge of `fsync` is detected at the clock edge where `fsync` is sampled 1 and the previous sample was 0. The next clock cycle is bit 0 of a frame. Holding `fsync` high does not restart the frame again, and a level that is already high when reset is released is not an edge.
- R3: With `rate_sel`=0 the frame has 193 bits. Bit 0 is the framing slot, in which `chan_clk` and `bit8` are low. Channels 1 to 24 occupy bits 1 to 192, MSB first. After bit 192 the count returns to bit 0 without a sync.
- R4: With `rate_sel`=1 the frame has 256 bits. Channel 1 starts at bit 0, and the frame holds 32 channels. After bit 255 the count returns to bit 0 without a sync.
- R5: `chan_clk` is high during the first four bit times of every channel slot and low during the last four, so it rises on each channel boundary.
- R6: `bit8` is high exactly during the eighth (last) bit time of every channel slot.
- R7: `chan_hi` is high during all bits of channels 25 to 32 when `rate_sel`=1. It is never high when `rate_sel`=0.
- R8: The first frame after the first sync edge is frame 0 of a multiframe. The frame index advances at every frame start and wraps after 12 frames when `mf_ext`=0 and after 24 frames when `mf_ext`=1. `mf_pulse` is high for exactly 65 clocks, starting in bit 0 of frame 0.
- R9: A sync edge in the middle of a frame restarts the bit count at bit 0 in the next cycle, and it counts as a new frame start for the multiframe index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | System frame sync; its rising edge starts a frame |
| rate_sel | input | 1 | 0: 193-bit frame, 1: 256-bit frame |
| mf_ext | input | 1 | 0: 12-frame multiframe, 1: 24-frame multiframe |
| chan_clk | output | 1 | High for the first half of every channel slot |
| bit8 | output | 1 | High during the LSB bit time of every channel |
| chan_hi | output | 1 | High during channels 25 to 32 of the 256-bit frame |
| mf_pulse | output | 1 | 65-clock pulse starting at each multiframe boundary |

## Verification
The assertions assume that `rate_sel` and `mf_ext` are held steady while the counters run. They may change only while reset is held. The framing-slot and wrap properties tie the bit position to the rate chosen at reset. The stimulus therefore sets both mode inputs before releasing reset and never toggles them afterwards. The bench does pulse `fsync` on frame boundaries and in the middle of frames, and it holds `fsync` high for long stretches. This exercises realignment and the level-versus-edge distinction without breaking those assumptions.

// File: rtl/t1st_pkg.sv
package t1st_pkg;
  typedef enum logic {
    RATE_NARROW = 1'b0,
    RATE_WIDE   = 1'b1
  } rate_e;

  typedef enum logic {
    MF_SHORT_MODE = 1'b0,
    MF_LONG_MODE  = 1'b1
  } mf_mode_e;
endpackage

// File: rtl/t1st_pos_ctr.sv
module t1st_pos_ctr
  import t1st_pkg::*;
#(
  parameter int FB_NARROW = 193,
  parameter int FB_WIDE   = 256,
  parameter int BPC       = 8,
  parameter int POS_W     = 8,
  parameter int BIT_W     = 3,
  parameter int CH_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             rate,
  output logic             locked_o,
  output logic             start_o,
  output logic [POS_W-1:0] pos_o,
  output logic             fslot_o,
  output logic [BIT_W-1:0] bit_o,
  output logic [CH_W-1:0]  ch_o
);
  localparam logic [POS_W-1:0] LAST_NARROW = POS_W'(FB_NARROW - 1);
  localparam logic [POS_W-1:0] LAST_WIDE   = POS_W'(FB_WIDE - 1);
  localparam logic [BIT_W-1:0] LAST_BIT    = BIT_W'(BPC - 1);

  logic             fsync_q;
  logic             locked_q;
  logic [POS_W-1:0] pos_q;
  logic             fslot_q;
  logic [BIT_W-1:0] bit_q;
  logic [CH_W-1:0]  ch_q;
  logic             sync_edge;
  logic             at_last;
  logic             start;
  logic [POS_W-1:0] last_pos;

  always_comb begin
    last_pos  = (rate_e'(rate) == RATE_WIDE) ? LAST_WIDE : LAST_NARROW;
    sync_edge = fsync & ~fsync_q;
    at_last   = locked_q & (pos_q == last_pos);
    start     = sync_edge | at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsync_q  <= 1'b1;
      locked_q <= 1'b0;
      pos_q    <= '0;
      fslot_q  <= 1'b0;
      bit_q    <= '0;
      ch_q     <= '0;
    end else begin
      fsync_q <= fsync;
      if (sync_edge) locked_q <= 1'b1;
      if (start) begin
        pos_q   <= '0;
        fslot_q <= (rate_e'(rate) == RATE_NARROW);
        bit_q   <= '0;
        ch_q    <= '0;
      end else if (locked_q) begin
        pos_q <= pos_q + 1'b1;
        if (fslot_q) begin
          fslot_q <= 1'b0;
        end else if (bit_q == LAST_BIT) begin
          bit_q <= '0;
          ch_q  <= ch_q + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign locked_o = locked_q;
  assign start_o  = start;
  assign pos_o    = pos_q;
  assign fslot_o  = fslot_q;
  assign bit_o    = bit_q;
  assign ch_o     = ch_q;

  a_r2_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge |=> (pos_q == '0));

  a_r3_fslot_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fslot_q |-> (pos_q == '0) && (rate_e'(rate) == RATE_NARROW));

  a_r3_narrow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && rate_e'(rate) == RATE_NARROW && pos_q == LAST_NARROW) |=> (pos_q == '0));

  a_r4_wide_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && rate_e'(rate) == RATE_WIDE && pos_q == LAST_WIDE) |=> (pos_q == '0) && !fslot_q);

  a_r9_idle_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> (pos_q == '0) && !fslot_q);
endmodule

// File: rtl/t1st_mf_gen.sv
module t1st_mf_gen
  import t1st_pkg::*;
#(
  parameter int MF_SHORT = 12,
  parameter int MF_LONG  = 24,
  parameter int MF_HOLD  = 65,
  parameter int FR_W     = 5,
  parameter int HOLD_W   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ext_mode,
  output logic mf_o
);
  localparam logic [FR_W-1:0]   LAST_SHORT = FR_W'(MF_SHORT - 1);
  localparam logic [FR_W-1:0]   LAST_LONG  = FR_W'(MF_LONG - 1);
  localparam logic [HOLD_W-1:0] HOLD_VAL   = HOLD_W'(MF_HOLD);

  logic              have_q;
  logic [FR_W-1:0]   fidx_q;
  logic [FR_W-1:0]   fidx_d;
  logic [FR_W-1:0]   last_fr;
  logic [HOLD_W-1:0] rem_q;
  logic              load;

  always_comb begin
    last_fr = (mf_mode_e'(ext_mode) == MF_LONG_MODE) ? LAST_LONG : LAST_SHORT;
    if (!have_q || fidx_q >= last_fr) fidx_d = '0;
    else                              fidx_d = fidx_q + 1'b1;
    load = start && (fidx_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      fidx_q <= '0;
      rem_q  <= '0;
    end else begin
      if (start) begin
        have_q <= 1'b1;
        fidx_q <= fidx_d;
      end
      if (load)              rem_q <= HOLD_VAL;
      else if (rem_q != '0)  rem_q <= rem_q - 1'b1;
    end
  end

  assign mf_o = (rem_q != '0);

  a_r8_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= HOLD_VAL);

  a_r8_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q != '0 && !load) |=> (rem_q == $past(rem_q) - 1'b1));

  a_r8_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    fidx_q <= LAST_LONG);
endmodule

// File: rtl/t1st_slot_dec.sv
module t1st_slot_dec
  import t1st_pkg::*;
#(
  parameter int BPC     = 8,
  parameter int HI_CHAN = 24,
  parameter int BIT_W   = 3,
  parameter int CH_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             locked,
  input  logic             rate,
  input  logic             fslot,
  input  logic [BIT_W-1:0] bit_ix,
  input  logic [CH_W-1:0]  ch_ix,
  output logic             chan_clk_o,
  output logic             bit8_o,
  output logic             chan_hi_o
);
  localparam logic [BIT_W-1:0] HALF     = BIT_W'(BPC / 2);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BPC - 1);
  localparam logic [CH_W-1:0]  HI_START = CH_W'(HI_CHAN);

  logic in_chan;

  always_comb begin
    in_chan    = locked & ~fslot;
    chan_clk_o = in_chan & (bit_ix < HALF);
    bit8_o     = in_chan & (bit_ix == LAST_BIT);
    chan_hi_o  = in_chan & (rate_e'(rate) == RATE_WIDE) & (ch_ix >= HI_START);
  end

  a_r6_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit8_o && chan_clk_o));

  a_r7_hi_needs_wide: assert property (@(posedge clk) disable iff (!rst_n)
    chan_hi_o |-> (rate_e'(rate) == RATE_WIDE));

  a_r5_rise_after_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (bit8_o && !fslot) |=> (chan_clk_o || fslot || !locked || bit_ix == '0));
endmodule

// File: rtl/t1_sys_timing.sv
module t1_sys_timing
  import t1st_pkg::*;
#(
  parameter int FB_NARROW = 193,
  parameter int FB_WIDE   = 256,
  parameter int BPC       = 8,
  parameter int HI_CHAN   = 24,
  parameter int MF_SHORT  = 12,
  parameter int MF_LONG   = 24,
  parameter int MF_HOLD   = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic rate_sel,
  input  logic mf_ext,
  output logic chan_clk,
  output logic bit8,
  output logic chan_hi,
  output logic mf_pulse
);
  localparam int POS_W  = $clog2(FB_WIDE);
  localparam int BIT_W  = $clog2(BPC);
  localparam int CH_W   = $clog2(FB_WIDE / BPC);
  localparam int FR_W   = $clog2(MF_LONG);
  localparam int HOLD_W = $clog2(MF_HOLD + 1);

  logic             locked;
  logic             start;
  logic [POS_W-1:0] pos;
  logic             fslot;
  logic [BIT_W-1:0] bit_ix;
  logic [CH_W-1:0]  ch_ix;

  t1st_pos_ctr #(
    .FB_NARROW(FB_NARROW), .FB_WIDE(FB_WIDE), .BPC(BPC),
    .POS_W(POS_W), .BIT_W(BIT_W), .CH_W(CH_W)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rate(rate_sel),
    .locked_o(locked), .start_o(start), .pos_o(pos), .fslot_o(fslot),
    .bit_o(bit_ix), .ch_o(ch_ix)
  );

  t1st_mf_gen #(
    .MF_SHORT(MF_SHORT), .MF_LONG(MF_LONG), .MF_HOLD(MF_HOLD),
    .FR_W(FR_W), .HOLD_W(HOLD_W)
  ) u_mf (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_mode(mf_ext), .mf_o(mf_pulse)
  );

  t1st_slot_dec #(
    .BPC(BPC), .HI_CHAN(HI_CHAN), .BIT_W(BIT_W), .CH_W(CH_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .locked(locked), .rate(rate_sel), .fslot(fslot),
    .bit_ix(bit_ix), .ch_ix(ch_ix),
    .chan_clk_o(chan_clk), .bit8_o(bit8), .chan_hi_o(chan_hi)
  );

  a_r1_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !chan_clk && !bit8 && !chan_hi && !mf_pulse);

  a_r8_pulse_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_pulse) |-> (pos == '0));
endmodule

// File: tb/tb_t1_sys_timing.sv
module tb_t1_sys_timing;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic rate_sel = 1'b0;
  logic mf_ext = 1'b0;
  logic chan_clk, bit8, chan_hi, mf_pulse;

  int checks = 0;
  int errors = 0;
  string phase = "R1 reset";

  // behavioural reference state
  int m_pos = 0;
  int m_fidx = 0;
  int m_rem = 0;
  bit m_locked = 0;
  bit m_have = 0;
  bit m_fprev = 1;

  always #2.5 clk = ~clk;

  t1_sys_timing dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rate_sel(rate_sel), .mf_ext(mf_ext),
    .chan_clk(chan_clk), .bit8(bit8), .chan_hi(chan_hi), .mf_pulse(mf_pulse)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_fidx = 0; m_rem = 0;
      m_locked = 0; m_have = 0; m_fprev = 1;
    end else begin
      bit edge_seen;
      bit start;
      int flen;
      int mflen;
      flen = rate_sel ? 256 : 193;
      mflen = mf_ext ? 24 : 12;
      edge_seen = fsync && !m_fprev;
      m_fprev = fsync;
      start = edge_seen || (m_locked && m_pos == flen - 1);
      if (start) begin
        m_pos = 0;
        if (!m_have) begin m_fidx = 0; m_have = 1; end
        else m_fidx = (m_fidx + 1) % mflen;
        if (m_fidx == 0) m_rem = 65;
        else if (m_rem > 0) m_rem = m_rem - 1;
      end else begin
        if (m_locked) m_pos = m_pos + 1;
        if (m_rem > 0) m_rem = m_rem - 1;
      end
      if (edge_seen) m_locked = 1;
    end
  end

  task automatic cmp(input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] act=%0b exp=%0b t=%0t", what, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_clk, e_b8, e_hi;
      int b, ch;
      e_clk = 0; e_b8 = 0; e_hi = 0;
      if (m_locked) begin
        if (!rate_sel && m_pos == 0) begin
          b = -1; ch = -1;
        end else if (!rate_sel) begin
          b = (m_pos - 1) % 8; ch = (m_pos - 1) / 8;
        end else begin
          b = m_pos % 8; ch = m_pos / 8;
        end
        if (b >= 0) begin
          e_clk = (b < 4);
          e_b8 = (b == 7);
          e_hi = rate_sel && (ch >= 24);
        end
      end
      cmp("R5 chan_clk", chan_clk, e_clk);
      cmp("R6 bit8", bit8, e_b8);
      cmp("R7 chan_hi", chan_hi, e_hi);
      cmp("R8 mf_pulse", mf_pulse, m_rem > 0);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sync(input int width);
    fsync = 1'b1;
    wait_cyc(width);
    fsync = 1'b0;
  endtask

  task automatic do_reset(input bit rs, input bit ext);
    rst_n = 1'b0;
    fsync = 1'b0;
    rate_sel = rs;
    mf_ext = ext;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  initial begin
    fork
      begin
        // R1: outputs stay quiet after reset with no sync
        phase = "R1 reset";
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        cmp("R1 chan_clk idle", chan_clk, 1'b0);
        cmp("R1 bit8 idle", bit8, 1'b0);
        cmp("R1 chan_hi idle", chan_hi, 1'b0);
        cmp("R1 mf_pulse idle", mf_pulse, 1'b0);
        wait_cyc(300);

        // R2 R3: narrow frame, periodic syncs on boundaries, 12-frame multiframe
        phase = "R2 R3 narrow periodic";
        wait_cyc(7);
        for (int f = 0; f < 14; f++) begin
          pulse_sync(2);
          wait_cyc(191);
        end
        // R3: free-running wrap without sync
        phase = "R3 narrow free-run";
        wait_cyc(193 * 13);

        // R2: held-high level does not restart
        phase = "R2 level held";
        fsync = 1'b1;
        wait_cyc(700);
        fsync = 1'b0;
        wait_cyc(50);

        // R9: mid-frame realign
        phase = "R9 mid-frame";
        pulse_sync(1);
        wait_cyc(77);
        pulse_sync(1);
        wait_cyc(193 * 12 + 40);

        // R1 R2: sync level high at reset release is not an edge
        phase = "R2 high at release";
        rst_n = 1'b0;
        fsync = 1'b1;
        rate_sel = 1'b1;
        mf_ext = 1'b1;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(40);
        cmp("R2 no lock from level", chan_clk | bit8 | chan_hi | mf_pulse, 1'b0);
        fsync = 1'b0;
        wait_cyc(5);

        // R4 R7 R8: wide frame, 24-frame multiframe, free-running
        phase = "R4 R7 wide ext";
        pulse_sync(3);
        wait_cyc(256 * 50);
        phase = "R9 wide realign";
        wait_cyc(13);
        pulse_sync(1);
        wait_cyc(256 * 25);

        // R8: wide frame with 12-frame multiframe
        phase = "R4 R8 wide short";
        do_reset(1'b1, 1'b0);
        wait_cyc(4);
        pulse_sync(1);
        wait_cyc(256 * 26);
      end
      begin
        wait_cyc(150000);
        errors++;
        checks++;
        $display("FAIL watchdog [%s] act=timeout exp=done", phase);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule